// File: doc/BRIEF.md
# PWM Cycle Interrupt Timer

This block produces the periodic tick and interrupt request that paces an audio pulse-width modulator. It holds a 16-bit control register and a 12-bit cycle register. The cycle register sets how many divided-clock periods make up one PWM cycle. The control register carries two 2-bit channel mode selects and a 4-bit interval field. The interval field sets how many completed PWM cycles pass between ticks. The divided system clock comes in as a clock-enable pulse (`clk_en`), so the whole block runs on one clock.

Two 16-bit write ports reach the same two registers, and both see the same read-back values:
- The host port may change only the low seven control bits.
- The processor port replaces the whole control word.

Any write restarts both counters from zero under the new settings. Each tick sets a sticky interrupt request when the interrupt enable is high. A clear strobe drops the request.

Top module: `pwm_tick_timer`

## Requirements
- R1: After reset, `ctrl_rdata` and `cycle_rdata` read 0, and `tick` and `irq` are low.
- R2: A cycle-register write (`*_sel` = 1) stores only data bits 11:0, and `cycle_rdata` returns the stored value, not the decoded one.
- R3: A host-port control write (`host_sel` = 0) loads data bits 6:0 into control bits 6:0 and leaves control bits 15:7 unchanged.
- R4: A processor-port control write (`cpu_sel` = 0) replaces all 16 control bits, including the interval field in bits 11:8. When both ports write the same register in one clock, the processor port wins.
- R5: One PWM cycle lasts (C − 1) clock-enable pulses, where C is the cycle register. A stored 0 counts as 4095.
- R6: `tick` is a one-clock pulse, raised in the clock after the enable pulse that completes the N-th PWM cycle since the last tick or write. N is control bits 11:8, and a stored 0 counts as 16.
- R7: No tick occurs while control bits 3:0 are all zero or while the effective cycle value is 1.
- R8: A write to either register on either port restarts both counters from zero and suppresses any tick in that clock.
- R9: A tick with `irq_en` high sets `irq` in the same clock as `tick`. `irq` stays high until a clock where `irq_clr` is high and no new enabled tick occurs. A tick with `irq_en` low leaves `irq` unchanged.
- R10: Counting advances only on clocks where `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Divided-clock enable pulse |
| host_we | input | 1 | Host-port write strobe |
| host_sel | input | 1 | Host target: 0 control, 1 cycle |
| host_wdata | input | 16 | Host write data |
| cpu_we | input | 1 | Processor-port write strobe |
| cpu_sel | input | 1 | Processor target: 0 control, 1 cycle |
| cpu_wdata | input | 16 | Processor write data |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt clear strobe |
| ctrl_rdata | output | 16 | Stored control register |
| cycle_rdata | output | 12 | Stored cycle register |
| tick | output | 1 | One-clock tick pulse |
| irq | output | 1 | Sticky interrupt request |

## Verification
The timer is run under several settings:
- a short cycle with interval 1, which checks the cycle length;
- a one-enable cycle with interval 0, which checks the decode of 0 as 16;
- cycle 0, which checks the decode of 0 as 4095;
- an enable that is high only every other clock, which shows the count halts without enables;
- cycle 1 and all channel modes off, which must yield no ticks.

A rewrite in the middle of a cycle is placed so that the tick it cancels would have fallen inside the counted window. This separates a real restart from a free-running counter.

Mixed host and processor writes show the control-bit masking and which port wins. An enable-off tick followed by a clear shows that the interrupt request is sticky and how it is cleared.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    localparam int CTRL_W = 16;
    localparam int CYC_W  = 12;
    localparam int IVL_W  = 4;
    localparam int IVL_LO = 8;
    localparam int MODE_W = 4;
    localparam logic [CTRL_W-1:0] HOST_MASK = 16'h007F;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CYC_W-1:0]  cyc;
    } regs_t;

    typedef struct packed {
        logic [CYC_W-1:0] cnt;
    } div_t;

    typedef struct packed {
        logic [IVL_W:0] icnt;
        logic           tick;
        logic           irq;
    } ivl_t;
endpackage

// File: rtl/pwm_reg_file.sv
module pwm_reg_file
    import pwm_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [CTRL_W-1:0] cpu_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CYC_W-1:0]  cyc_q,
    output logic              wr_any
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_we) begin
            if (host_sel) r_d.cyc  = host_wdata[CYC_W-1:0];
            else          r_d.ctrl = (r_q.ctrl & ~HOST_MASK) | (host_wdata & HOST_MASK);
        end
        if (cpu_we) begin
            if (cpu_sel) r_d.cyc  = cpu_wdata[CYC_W-1:0];
            else         r_d.ctrl = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_q = r_q.ctrl;
    assign cyc_q  = r_q.cyc;
    assign wr_any = host_we | cpu_we;

    assert_host_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_sel && !(cpu_we && !cpu_sel))
        |=> (ctrl_q[CTRL_W-1:7] == $past(ctrl_q[CTRL_W-1:7])));

    assert_cpu_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cpu_sel) |=> (ctrl_q == $past(cpu_wdata)));
endmodule

// File: rtl/pwm_cycle_div.sv
module pwm_cycle_div
    import pwm_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              restart,
    input  logic [MODE_W-1:0] mode,
    input  logic [CYC_W-1:0]  cyc,
    output logic              cycle_done
);
    localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

    div_t s_d, s_q;
    logic [CYC_W-1:0] eff_cyc;
    logic             run;

    always_comb begin
        eff_cyc    = (cyc == '0) ? CYC_MAX : cyc;
        run        = (mode != '0) && (eff_cyc != CYC_W'(1));
        cycle_done = clk_en && run && !restart && (s_q.cnt == eff_cyc - CYC_W'(2));
        s_d        = s_q;
        if (restart || !run)  s_d.cnt = '0;
        else if (cycle_done)  s_d.cnt = '0;
        else if (clk_en)      s_d.cnt = s_q.cnt + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_cnt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !restart && run) |=> $stable(s_q.cnt));
endmodule

// File: rtl/pwm_tick_irq.sv
module pwm_tick_irq
    import pwm_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             cycle_done,
    input  logic [IVL_W-1:0] ivl,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             tick,
    output logic             irq
);
    ivl_t s_d, s_q;
    logic [IVL_W:0] eff_ivl;

    always_comb begin
        eff_ivl = (ivl == '0) ? (IVL_W+1)'(1 << IVL_W) : {1'b0, ivl};
        s_d     = s_q;
        s_d.tick = cycle_done && (s_q.icnt == eff_ivl - (IVL_W+1)'(1));
        if (restart)         s_d.icnt = '0;
        else if (s_d.tick)   s_d.icnt = '0;
        else if (cycle_done) s_d.icnt = s_q.icnt + (IVL_W+1)'(1);
        s_d.irq = (s_q.irq && !irq_clr) || (s_d.tick && irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
    assign irq  = s_q.irq;

    assert_irq_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && irq_en && s_d.tick) |=> irq);

    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/pwm_tick_timer.sv
module pwm_tick_timer
    import pwm_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [CTRL_W-1:0] cpu_wdata,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [CYC_W-1:0]  cycle_rdata,
    output logic              tick,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              wr_any;
    logic              cycle_done;

    pwm_reg_file u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .ctrl_q(ctrl_q), .cyc_q(cyc_q), .wr_any(wr_any)
    );

    pwm_cycle_div u_div (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .restart(wr_any),
        .mode(ctrl_q[MODE_W-1:0]), .cyc(cyc_q), .cycle_done(cycle_done)
    );

    pwm_tick_irq u_ivl (
        .clk(clk), .rst_n(rst_n), .restart(wr_any), .cycle_done(cycle_done),
        .ivl(ctrl_q[IVL_LO +: IVL_W]), .irq_en(irq_en), .irq_clr(irq_clr),
        .tick(tick), .irq(irq)
    );

    assign ctrl_rdata  = ctrl_q;
    assign cycle_rdata = cyc_q;

    assert_tick_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ((ctrl_q[MODE_W-1:0] != '0) && (cyc_q != CYC_W'(1))));

    assert_tick_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(clk_en));

    assert_write_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we || cpu_we) |=> !tick);
endmodule

// File: tb/test_pwm_tick_timer.sv
module test_pwm_tick_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
    logic host_we = 1'b0, host_sel = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
    logic [15:0] host_wdata = '0, cpu_wdata = '0;
    logic irq_en = 1'b0, irq_clr = 1'b0;
    logic [15:0] ctrl_rdata;
    logic [11:0] cycle_rdata;
    logic tick, irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_ctrl = 0, m_cyc = 0, m_cnt = 0, m_icnt = 0, m_tick = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_tick_timer i_pwm_tick_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .irq_en(irq_en), .irq_clr(irq_clr),
        .ctrl_rdata(ctrl_rdata), .cycle_rdata(cycle_rdata), .tick(tick), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cyc = 0; m_cnt = 0; m_icnt = 0; m_tick = 0; m_irq = 0;
        end else begin
            int ec, en, wr, run, fin;
            ec  = (m_cyc == 0) ? 4095 : m_cyc;
            en  = (m_ctrl >> 8) & 15;
            if (en == 0) en = 16;
            wr  = host_we || cpu_we;
            run = ((m_ctrl & 15) != 0) && (ec != 1);
            fin = clk_en && run && !wr && (m_cnt == ec - 2);
            m_tick = fin && (m_icnt == en - 1);
            if (wr || !run) m_cnt = 0;
            else if (clk_en) m_cnt = fin ? 0 : m_cnt + 1;
            if (wr) m_icnt = 0;
            else if (fin) m_icnt = m_tick ? 0 : m_icnt + 1;
            m_irq = (m_irq && !irq_clr) || (m_tick && irq_en);
            if (host_we && !host_sel) m_ctrl = (m_ctrl & 'hFF80) | (host_wdata & 'h7F);
            if (host_we && host_sel)  m_cyc  = host_wdata & 'hFFF;
            if (cpu_we && !cpu_sel)   m_ctrl = cpu_wdata;
            if (cpu_we && cpu_sel)    m_cyc  = cpu_wdata & 'hFFF;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 ctrl model", ctrl_rdata, m_ctrl);
            check("R2 cycle model", cycle_rdata, m_cyc);
            check("R6 tick model", tick, m_tick);
            check("R9 irq model", irq, m_irq);
        end
    end

    task automatic wr(bit cpu, bit sel, logic [15:0] d);
        @(negedge clk);
        if (cpu) begin cpu_we = 1; cpu_sel = sel; cpu_wdata = d; end
        else     begin host_we = 1; host_sel = sel; host_wdata = d; end
        @(negedge clk);
        cpu_we = 0; host_we = 0;
    endtask

    task automatic count_ticks(int n, bit alt, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            clk_en = alt ? ((i % 2) == 0) : 1'b1;
            @(negedge clk);
            c += tick;
        end
        clk_en = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset ctrl", ctrl_rdata, 0);
        check("R1 reset cycle", cycle_rdata, 0);
        check("R1 reset tick/irq", {tick, irq}, 0);

        wr(0, 1, 16'hF123);
        check("R2 cycle mask", cycle_rdata, 'h123);
        wr(0, 0, 16'hFFFF);
        check("R3 host sets low bits", ctrl_rdata, 'h007F);
        wr(1, 0, 16'hABCD);
        check("R4 cpu full write", ctrl_rdata, 'hABCD);
        wr(0, 0, 16'h0000);
        check("R3 host keeps high bits", ctrl_rdata, 'hAB80);
        @(negedge clk);
        host_we = 1; host_sel = 0; host_wdata = 16'h0011;
        cpu_we = 1; cpu_sel = 0; cpu_wdata = 16'h0222;
        @(negedge clk);
        host_we = 0; cpu_we = 0;
        check("R4 cpu wins", ctrl_rdata, 'h0222);

        // cycle 5, interval 1: period 4 clocks
        wr(1, 1, 16'd5);
        wr(1, 0, 16'h0101);
        count_ticks(40, 0, c);
        check("R5 cycle length", c, 10);

        // cycle 2, interval 0 -> 16: period 16 clocks
        wr(1, 1, 16'd2);
        wr(1, 0, 16'h0002);
        count_ticks(64, 0, c);
        check("R6 interval zero is 16", c, 4);

        // interval 3 with cycle 2
        wr(1, 0, 16'h0304);
        count_ticks(30, 0, c);
        check("R6 interval 3", c, 10);

        // cycle 0 -> 4095: period 4094 clocks
        wr(1, 1, 16'd0);
        wr(1, 0, 16'h0108);
        count_ticks(8188, 0, c);
        check("R5 cycle zero is 4095", c, 2);

        // enable every other clock: cycle 5, interval 1 -> period 8 clocks
        wr(1, 1, 16'd5);
        wr(1, 0, 16'h0101);
        count_ticks(40, 1, c);
        check("R10 enable gating", c, 5);

        // suppression
        wr(1, 1, 16'd1);
        count_ticks(50, 0, c);
        check("R7 cycle one silent", c, 0);
        wr(1, 1, 16'd5);
        wr(1, 0, 16'h0130);
        count_ticks(50, 0, c);
        check("R7 modes off silent", c, 0);

        // restart in mid cycle
        wr(1, 0, 16'h0101);
        count_ticks(1, 0, c);
        wr(0, 0, 16'h0001);
        count_ticks(3, 0, c);
        check("R8 restart cancels tick", c, 0);
        count_ticks(1, 0, c);
        check("R8 tick after restart", c, 1);

        // interrupt
        wr(1, 0, 16'h0101);
        irq_en = 1;
        count_ticks(4, 0, c);
        check("R9 irq set by tick", irq, 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0; irq_en = 0;
        check("R9 irq cleared", irq, 0);
        count_ticks(3, 0, c);
        check("R9 tick seen while disabled", c, 1);
        check("R9 irq stays low when disabled", irq, 0);
        irq_en = 1;
        count_ticks(12, 0, c);
        check("R9 irq sticky", irq, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule